// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches a bank of already-synchronized general-purpose pin levels. For each pin it detects a configured event and records it in a sticky status bit. Per-pin enable bits then decide which recorded events drive a single combined interrupt request. Two configuration bits per pin select the event kind: a level/edge selector and a polarity flip. Together they give four modes: rising edge, falling edge, low level and high level.

Status and enable bits are packed 32 to a word. Pin `p` sits at bit `p % 32` of word `p / 32`. Software reaches each word through a per-word write strobe that shares one data bus. It reads every word back in parallel. Status bits are cleared by writing ones. A fresh event that lands in the same cycle as its clear always wins, so no event is lost between reading and acknowledging. Address decoding and pad logic sit outside this block.

Top module: `pin_event_irq`

## Requirements
- R1: With `{trig_level,trig_inv}` = 2'b00 a pin's status bit sets on the clock edge that samples the pin high after it was sampled low. A high-to-low change sets nothing.
- R2: With `{trig_level,trig_inv}` = 2'b01 a pin's status bit sets on a high-to-low change of its sampled level. A low-to-high change sets nothing.
- R3: With `{trig_level,trig_inv}` = 2'b10 the status bit is set on every clock edge on which the pin is low. A clear issued while the pin stays low therefore leaves it set.
- R4: With `{trig_level,trig_inv}` = 2'b11 the status bit is set on every clock edge on which the pin is high.
- R5: Asserting `stat_wr[w]` clears each status bit of word `w` whose `wr_data` bit is 1. Bits written with 0 keep their value. A status bit never drops without such a write.
- R6: When an event for a pin and a clear of that pin's status bit occur in the same cycle, the bit is set afterwards.
- R7: Asserting `en_wr[w]` loads `wr_data` into enable word `w`, which is readable on `en_rd` the next cycle. Status bits set regardless of their enable bit.
- R8: `irq_out` equals the OR over all pins of (status AND enable), delayed by one clock.
- R9: A synchronous active-low reset clears all status, enable and `irq_out`. The first sample after reset is taken as the previous level, so no edge is recorded for it.
- R10: Status and enable bits at positions at or above the pin count never set and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level | input | NUM_PINS | Synchronized pin levels |
| trig_level | input | NUM_PINS | Per-pin selector: 0 edge, 1 level |
| trig_inv | input | NUM_PINS | Per-pin polarity flip (see R1 to R4) |
| stat_wr | input | NUM_WORDS | Per-word write-one-to-clear strobe for status |
| en_wr | input | NUM_WORDS | Per-word load strobe for enable |
| wr_data | input | WORD_W | Shared write data |
| stat_rd | output | NUM_WORDS*WORD_W | All status words, word 0 in the low bits |
| en_rd | output | NUM_WORDS*WORD_W | All enable words, word 0 in the low bits |
| irq_out | output | 1 | Registered combined interrupt request |

## Verification
The bench targets an edge that arrives in the same cycle as its own clear. A design that lets the clear win would silently drop that event. It holds a low-level pin through a clear to catch a design that treats level mode as one-shot. It checks the first cycle after reset with every pin high, where a design whose previous-sample register starts at zero would report 94 false rising edges. It loads all ones into the last enable word to expose storage above pin 93. A long random run with changing modes compares every cycle against a reference model, which catches an `irq_out` that is off by one cycle or ignores the enable mask.

// File: rtl/pin_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared trigger-mode encoding and the per-pin event rule.
// Assumes the mode is formed as {level_select, invert}.
package pin_irq_pkg;

    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_mode_e;

    // Returns 1 when a pin's current sample constitutes an event in mode m.
    function automatic logic trig_hit(trig_mode_e m, logic prev, logic cur, logic primed);
        logic hit;
        unique case (m)
            TRIG_RISE: hit = primed & ~prev & cur;
            TRIG_FALL: hit = primed & prev & ~cur;
            TRIG_LOW:  hit = ~cur;
            TRIG_HIGH: hit = cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pin_event_detect.sv
`timescale 1ns/1ps
// Module: pin_event_detect
// Keeps the previous sample of each pin and flags per-pin events from the
// configured mode. Assumes pin_level is already synchronous to clk. The first
// sample after reset only primes the history, so edges cannot fire on it.
module pin_event_detect #(
    parameter int NUM_PINS = 94
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] trig_level,
    input  logic [NUM_PINS-1:0] trig_inv,
    output logic [NUM_PINS-1:0] evt
);
    import pin_irq_pkg::*;

    logic [NUM_PINS-1:0] prev_q;
    logic                primed_q;

    // Purpose: capture the previous sample and note that history is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= pin_level;
            primed_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign evt[i] = trig_hit(trig_mode_e'({trig_level[i], trig_inv[i]}),
                                 prev_q[i], pin_level[i], primed_q);
    end

endmodule

// File: rtl/irq_status_word.sv
`timescale 1ns/1ps
// Module: irq_status_word
// One word of sticky status plus its enable mask. Set beats clear in the
// same cycle. Bits at or above VALID_BITS are held at zero.
module irq_status_word #(
    parameter int WORD_W     = 32,
    parameter int VALID_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] evt,
    input  logic              clr_stb,
    input  logic              en_stb,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] stat_q,
    output logic [WORD_W-1:0] en_q
);
    localparam logic [WORD_W-1:0] VMASK = {WORD_W{1'b1}} >> (WORD_W - VALID_BITS);

    logic [WORD_W-1:0] clr_mask;
    logic [WORD_W-1:0] stat_nxt;

    // Purpose: form the clear mask and the next status, with set priority.
    always_comb begin
        clr_mask = clr_stb ? wr_data : '0;
        stat_nxt = ((stat_q & ~clr_mask) | evt) & VMASK;
    end

    // Purpose: hold status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_nxt;
    end

    // Purpose: hold enable bits, loaded whole on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (en_stb) en_q <= wr_data & VMASK;
    end

endmodule

// File: rtl/irq_merge.sv
`timescale 1ns/1ps
// Module: irq_merge
// Registers the OR of all enabled status bits into one request line.
module irq_merge #(
    parameter int WIDTH = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] stat,
    input  logic [WIDTH-1:0] en,
    output logic             irq_q
);
    // Purpose: register the combined request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(stat & en);
    end

endmodule

// File: rtl/pin_event_irq.sv
`timescale 1ns/1ps
// Module: pin_event_irq (top)
// Detects per-pin events, keeps them in write-one-to-clear status words and
// raises one registered interrupt through per-pin enables. Assumes synchronized
// pin inputs. Address decode is external: one strobe per word.
module pin_event_irq #(
    parameter int NUM_PINS  = 94,
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PINS-1:0]           pin_level,
    input  logic [NUM_PINS-1:0]           trig_level,
    input  logic [NUM_PINS-1:0]           trig_inv,
    input  logic [NUM_WORDS-1:0]          stat_wr,
    input  logic [NUM_WORDS-1:0]          en_wr,
    input  logic [WORD_W-1:0]             wr_data,
    output logic [NUM_WORDS*WORD_W-1:0]   stat_rd,
    output logic [NUM_WORDS*WORD_W-1:0]   en_rd,
    output logic                          irq_out
);
    localparam int TOTAL = NUM_WORDS * WORD_W;

    logic [NUM_PINS-1:0] evt;
    logic [TOTAL-1:0]    evt_pad;

    pin_event_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_level  (pin_level),
        .trig_level (trig_level),
        .trig_inv   (trig_inv),
        .evt        (evt)
    );

    assign evt_pad = TOTAL'(evt);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam int VB = ((NUM_PINS - w * WORD_W) >= WORD_W) ? WORD_W
                                                                 : (NUM_PINS - w * WORD_W);
        irq_status_word #(.WORD_W(WORD_W), .VALID_BITS(VB)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_pad[w*WORD_W +: WORD_W]),
            .clr_stb (stat_wr[w]),
            .en_stb  (en_wr[w]),
            .wr_data (wr_data),
            .stat_q  (stat_rd[w*WORD_W +: WORD_W]),
            .en_q    (en_rd[w*WORD_W +: WORD_W])
        );
    end

    irq_merge #(.WIDTH(TOTAL)) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .stat  (stat_rd),
        .en    (en_rd),
        .irq_q (irq_out)
    );

endmodule

// File: rtl/pin_event_irq_chk.sv
`timescale 1ns/1ps
// Module: pin_event_irq_chk
// Port-level properties of pin_event_irq, attached by bind below.
module pin_event_irq_chk #(
    parameter int NUM_PINS  = 94,
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_PINS-1:0]         pin_level,
    input logic [NUM_PINS-1:0]         trig_level,
    input logic [NUM_PINS-1:0]         trig_inv,
    input logic [NUM_WORDS-1:0]        stat_wr,
    input logic [NUM_WORDS-1:0]        en_wr,
    input logic [WORD_W-1:0]           wr_data,
    input logic [NUM_WORDS*WORD_W-1:0] stat_rd,
    input logic [NUM_WORDS*WORD_W-1:0] en_rd,
    input logic                        irq_out
);
    localparam int TOTAL = NUM_WORDS * WORD_W;

    // R3 R4 R6: an active level always leaves the status bit set, clear or not.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_lvl
        p_level_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_level[i] && (pin_level[i] == trig_inv[i])) |=> stat_rd[i]);
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_w
        localparam int VB = ((NUM_PINS - w * WORD_W) >= WORD_W) ? WORD_W
                                                                 : (NUM_PINS - w * WORD_W);
        localparam logic [WORD_W-1:0] VM = {WORD_W{1'b1}} >> (WORD_W - VB);

        // R5: without a clear strobe no status bit of the word drops.
        p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !stat_wr[w] |=> ((stat_rd[w*WORD_W +: WORD_W] & $past(stat_rd[w*WORD_W +: WORD_W]))
                             == $past(stat_rd[w*WORD_W +: WORD_W])));

        // R7: enable word loads the written data.
        p_en_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
            en_wr[w] |=> (en_rd[w*WORD_W +: WORD_W] == ($past(wr_data) & VM)));

        // R7: enable word holds without a strobe.
        p_en_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !en_wr[w] |=> $stable(en_rd[w*WORD_W +: WORD_W]));
    end

    // R8: request follows the enabled status one cycle later.
    p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_rd & en_rd)) |=> irq_out);
    p_irq_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_rd & en_rd)) |=> !irq_out);

    // R9: reset empties everything.
    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (stat_rd == '0 && en_rd == '0 && !irq_out));

    // R10: storage above the pin count reads zero.
    if (TOTAL > NUM_PINS) begin : g_tail
        p_tail_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_rd[TOTAL-1:NUM_PINS] == '0) && (en_rd[TOTAL-1:NUM_PINS] == '0));
    end

endmodule

bind pin_event_irq pin_event_irq_chk #(
    .NUM_PINS  (NUM_PINS),
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_level  (pin_level),
    .trig_level (trig_level),
    .trig_inv   (trig_inv),
    .stat_wr    (stat_wr),
    .en_wr      (en_wr),
    .wr_data    (wr_data),
    .stat_rd    (stat_rd),
    .en_rd      (en_rd),
    .irq_out    (irq_out)
);

// File: tb/sim_pin_event_irq.sv
`timescale 1ns/1ps
// Bench for pin_event_irq: directed corner cases, then seeded random traffic,
// every cycle compared against a reference model written from the requirements.
module sim_pin_event_irq;
    localparam int NP = 94;
    localparam int WW = 32;
    localparam int NW = 3;
    localparam int TW = NW * WW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pin, tl, ti;
    logic [NW-1:0] sw, ew;
    logic [WW-1:0] wd;
    wire  [TW-1:0] srd, erd;
    wire           irq;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    logic [NP-1:0] m_prev;
    logic          m_primed;
    logic [TW-1:0] m_stat, m_en;
    logic          m_irq;

    always #2 clk = ~clk;  // 250 MHz

    pin_event_irq u0 (
        .clk(clk), .rst_n(rst_n), .pin_level(pin), .trig_level(tl), .trig_inv(ti),
        .stat_wr(sw), .en_wr(ew), .wr_data(wd),
        .stat_rd(srd), .en_rd(erd), .irq_out(irq)
    );

    function automatic logic [TW-1:0] valid_mask();
        return TW'({NP{1'b1}});
    endfunction

    task automatic chk(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: model next state from pre-edge inputs, then compare at negedge.
    task automatic tick();
        logic [TW-1:0] ev, clr, nstat, nen;
        logic          nirq;
        ev  = '0;
        clr = '0;
        nen = m_en;
        for (int i = 0; i < NP; i++) begin
            case ({tl[i], ti[i]})
                2'b00:   ev[i] = m_primed & ~m_prev[i] & pin[i];
                2'b01:   ev[i] = m_primed & m_prev[i] & ~pin[i];
                2'b10:   ev[i] = ~pin[i];
                default: ev[i] = pin[i];
            endcase
        end
        for (int w = 0; w < NW; w++) begin
            if (sw[w]) clr[w*WW +: WW] = wd;
            if (ew[w]) nen[w*WW +: WW] = wd;
        end
        nstat = ((m_stat & ~clr) | ev) & valid_mask();
        nen   = nen & valid_mask();
        nirq  = |(m_stat & m_en);
        @(posedge clk);
        @(negedge clk);
        if (!rst_n) begin
            m_stat = '0; m_en = '0; m_irq = 1'b0; m_prev = '0; m_primed = 1'b0;
        end else begin
            m_stat = nstat; m_en = nen; m_irq = nirq; m_prev = pin; m_primed = 1'b1;
        end
        chk("R5 status model", srd, m_stat);
        chk("R7 enable model", erd, m_en);
        chk("R8 irq model", TW'(irq), TW'(m_irq));
    endtask

    task automatic clr_stat(input int w, input logic [WW-1:0] d);
        sw[w] = 1'b1; wd = d;
        tick();
        sw = '0; wd = '0;
    endtask

    task automatic set_en(input int w, input logic [WW-1:0] d);
        ew[w] = 1'b1; wd = d;
        tick();
        ew = '0; wd = '0;
    endtask

    function automatic logic [TW-1:0] bitv(input int p);
        return TW'(1) << p;
    endfunction

    initial begin
        #400000;
        n_fail++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5A5A));
        rst_n = 1'b0; pin = '1; tl = '0; ti = '0; sw = '0; ew = '0; wd = '0;
        m_stat = '0; m_en = '0; m_irq = 1'b0; m_prev = '0; m_primed = 1'b0;
        @(negedge clk);
        repeat (3) tick();
        chk("R9 reset status", srd, '0);
        chk("R9 reset enable", erd, '0);
        chk("R9 reset irq", TW'(irq), '0);
        rst_n = 1'b1;
        tick();  // all pins high on first sample: no rising edge
        chk("R9 first sample no edge", srd, '0);
        pin = '0;
        tick();
        chk("R1 falling ignored in rise mode", srd, '0);

        // R1 rising edge on pin 5
        pin[5] = 1'b1; tick();
        chk("R1 rise sets", srd, bitv(5));
        pin[5] = 1'b0; tick();
        chk("R1 sticky after fall", srd, bitv(5));
        // R5 write zero keeps, write one clears
        clr_stat(0, 32'h0);
        chk("R5 zero write no effect", srd, bitv(5));
        clr_stat(0, 32'h20);
        chk("R5 one write clears", srd, '0);

        // R2 falling on pin 40
        ti[40] = 1'b1; tick();
        pin[40] = 1'b1; tick();
        chk("R2 rise ignored", srd, '0);
        pin[40] = 1'b0; tick();
        chk("R2 fall sets", srd, bitv(40));
        clr_stat(1, 32'h100);
        chk("R2 cleared", srd, '0);

        // R3 level low on pin 70 (pin already low)
        tl[70] = 1'b1; tick();
        chk("R3 low sets", srd, bitv(70));
        clr_stat(2, 32'h40);
        chk("R3 clear while low stays set", srd, bitv(70));
        pin[70] = 1'b1; tick();
        clr_stat(2, 32'h40);
        chk("R3 clear after release", srd, '0);

        // R4 level high on pin 93
        tl[93] = 1'b1; ti[93] = 1'b1; tick();
        chk("R4 low ignored", srd, '0);
        pin[93] = 1'b1; tick();
        chk("R4 high sets", srd, bitv(93));
        pin[93] = 1'b0;
        clr_stat(2, 32'h2000_0000);
        chk("R4 cleared", srd, '0);

        // R6 edge coinciding with clear on pin 10
        pin[10] = 1'b1; tick();
        pin[10] = 1'b0; tick();
        pin[10] = 1'b1;
        clr_stat(0, 32'h400);
        chk("R6 new edge beats clear", srd, bitv(10));
        clr_stat(0, 32'h400);
        chk("R6 later clear works", srd, '0);

        // R7 status sets with enable off; R8 timing of irq
        pin[10] = 1'b0; tick();
        pin[10] = 1'b1; tick();
        chk("R7 status set while disabled", srd, bitv(10));
        tick();
        chk("R7 disabled no irq", TW'(irq), '0);
        set_en(0, 32'h400);
        chk("R7 enable readback", erd, TW'(32'h400));
        chk("R8 irq one cycle late", TW'(irq), '0);
        tick();
        chk("R8 irq asserted", TW'(irq), TW'(1));
        clr_stat(0, 32'h400);
        chk("R8 irq still registered", TW'(irq), TW'(1));
        tick();
        chk("R8 irq drops", TW'(irq), '0);

        // R10 bits past the last pin
        set_en(2, 32'hFFFF_FFFF);
        chk("R10 top enable masked", erd[95:64], TW'(32'h3FFF_FFFF));
        set_en(2, 32'h0);
        set_en(0, 32'h0);

        // random phase
        for (int c = 0; c < 4000; c++) begin
            logic [TW-1:0] f;
            f = {$urandom(), $urandom(), $urandom()} & {$urandom(), $urandom(), $urandom()}
              & {$urandom(), $urandom(), $urandom()};
            pin = pin ^ NP'(f);
            if (($urandom() % 64) == 0) begin
                tl = NP'({$urandom(), $urandom(), $urandom()}) & NP'({$urandom(), $urandom(), $urandom()});
                ti = NP'({$urandom(), $urandom(), $urandom()});
            end
            sw = (($urandom() % 4) == 0) ? NW'($urandom()) : '0;
            ew = (($urandom() % 16) == 0) ? NW'($urandom()) : '0;
            wd = $urandom();
            tick();
            if ((c % 1000) == 999) chk("R10 status tail zero", srd[95:94], '0);
        end
        sw = '0; ew = '0;
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule